// File: doc/BRIEF.md
# Floppy Controller Host Register Front End

This block is the processor-facing register layer of a floppy disk controller. A byte-wide register bus with a 3-bit offset, separate read and write strobes and write data feeds it. It combines configuration bytes and live status from the controller core into two read-only bytes: a tape/drive information byte and a main status byte. It also captures two write-only rate settings: a data rate byte and a configuration control byte. From these it produces the effective transfer rate code and the write precompensation code.

Two pieces of history shape what the processor sees. The drive-type bits in the tape/drive byte come from the drive that was selected most recently through the digital output register. The rate code follows whichever of the two rate registers was written last. Reads only return data. A read strobe loads a registered read-data byte, which holds its value until the next read.

The offsets are fixed: 2 is the digital output register (write), 3 is the tape/drive byte (read), 4 is the main status byte on read and the data rate byte on write, and 7 is the configuration control byte (write).

Top module: `fdc_host_regs`

## Requirements
- R1: A read of offset 3 returns bits 7:6 equal to `cfg_misc[5:4]` (media identity) and bits 3:2 equal to `cfg_misc[7:6]` (boot drive number).
- R2: Bits 5:4 of the offset-3 byte equal the two-bit drive-type field of the last selected drive. Drive n uses `cfg_drive_types[2n+1:2n]`. Every write to offset 2 loads the selected drive from bits 1:0 of the write data, and after reset the selected drive is 0.
- R3: Bits 1:0 of the offset-3 byte equal `cfg_tape_drive`: 00 means no tape drive, 01 means drive 1, 10 means drive 2 and 11 means drive 3.
- R4: A read of offset 4 returns the main status byte. Bits 3:0 are the per-drive seek-busy flags of drives 0 to 3, bit 4 is command busy, bit 5 is the non-DMA execution flag, bit 6 is direction (1 means controller to processor), and bit 7 is request-for-master.
- R5: A write to offset 4 loads the rate from bits 1:0 and the precompensation code from bits 4:2. A later read of offset 4 still returns the status byte, not the written value.
- R6: A write to offset 7 loads the rate from bits 1:0 and leaves the precompensation code unchanged. `rate_code` always shows the rate of whichever of offsets 4 and 7 was written most recently.
- R7: After reset, `rate_code` is 00, `precomp_code` is 000, `bus_rdata` is 0x00 and the selected drive is 0.
- R8: A read of any offset other than 3 or 4 returns 0xFF.
- R9: Reads have no side effect: `rate_code`, `precomp_code` and the selected drive do not change on any read.
- R10: `bus_rdata` is updated on the clock edge that samples the read strobe. It holds its value while no read strobe is present, even when the core inputs change.
- R11: Writes to offsets 0, 1, 3, 5 and 6 change neither the rate, the precompensation code nor the selected drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cfg_misc | input | 8 | Configuration byte with media identity [5:4] and boot drive [7:6] |
| cfg_drive_types | input | 8 | Four two-bit drive-type fields, drive n at [2n+1:2n] |
| cfg_tape_drive | input | 2 | Tape drive assignment |
| drv_seek_busy | input | 4 | Per-drive seek in progress |
| core_cmd_busy | input | 1 | Read or write command in progress |
| core_nondma_exec | input | 1 | Non-DMA execution phase active |
| core_dir_to_host | input | 1 | Data direction, 1 means controller to processor |
| core_req_master | input | 1 | Data register ready for transfer |
| rate_code | output | 2 | Effective data rate code |
| precomp_code | output | 3 | Write precompensation code |

## Verification
The tape/drive byte is tried with several `cfg_misc` and drive-type patterns, each field holding a distinct value. This shows whether a field is picked from the wrong bit pair or whether two fields are swapped. Every drive is selected in turn, which shows whether the selected drive is latched and mapped to its own field. The status byte is driven with walking ones and alternating patterns, which exposes any misplaced bit. The rate is written in both orders (4 then 7, and 7 then 4) with different values, which shows whether the most recent write wins rather than a fixed register. Reads, writes to unused offsets and unimplemented offsets are each followed by read-back, which shows that none of them disturb stored state.

// File: rtl/fdc_host_pkg.sv
package fdc_host_pkg;

    localparam int ADDR_W     = 3;
    localparam int DATA_W     = 8;
    localparam int N_DRIVES   = 4;
    localparam int SEL_W      = $clog2(N_DRIVES);
    localparam int TYPE_W     = 2;
    localparam int RATE_W     = 2;
    localparam int PRECOMP_W  = 3;

    localparam logic [ADDR_W-1:0] OFS_DIGOUT = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_TAPE   = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_STRATE = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_CFGCTL = 3'd7;

    localparam logic [DATA_W-1:0] UNIMPL_BYTE = 8'hFF;

    typedef struct packed {
        logic [RATE_W-1:0]    drr_rate;
        logic [PRECOMP_W-1:0] precomp;
        logic [RATE_W-1:0]    ccr_rate;
        logic                 last_ccr;
    } rate_state_t;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
    } sel_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

endpackage

// File: rtl/fdc_sel_track.sv
module fdc_sel_track
    import fdc_host_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sel_wr,
    input  logic [SEL_W-1:0]           sel_wdata,
    input  logic [N_DRIVES*TYPE_W-1:0] cfg_types,
    output logic [SEL_W-1:0]           sel_out,
    output logic [TYPE_W-1:0]          drv_type
);

    sel_state_t st_d, st_q;
    logic [TYPE_W-1:0] fld [N_DRIVES];

    for (genvar g = 0; g < N_DRIVES; g++) begin : g_fld
        assign fld[g] = cfg_types[g*TYPE_W +: TYPE_W];
    end

    always_comb begin
        st_d = st_q;
        if (sel_wr) begin
            st_d.sel = sel_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_out  = st_q.sel;
    assign drv_type = fld[st_q.sel];

    // R2
    sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> sel_out == $past(sel_wdata));

    // R9
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_wr |=> $stable(sel_out));

endmodule

// File: rtl/fdc_rate_ctl.sv
module fdc_rate_ctl
    import fdc_host_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 drr_wr,
    input  logic                 ccr_wr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [RATE_W-1:0]    rate_code,
    output logic [PRECOMP_W-1:0] precomp_code
);

    localparam int PC_LO = RATE_W;

    rate_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (drr_wr) begin
            st_d.drr_rate = wdata[RATE_W-1:0];
            st_d.precomp  = wdata[PC_LO +: PRECOMP_W];
            st_d.last_ccr = 1'b0;
        end else if (ccr_wr) begin
            st_d.ccr_rate = wdata[RATE_W-1:0];
            st_d.last_ccr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rate_code    = st_q.last_ccr ? st_q.ccr_rate : st_q.drr_rate;
    assign precomp_code = st_q.precomp;

    // R5
    drr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drr_wr |=> rate_code == $past(wdata[RATE_W-1:0]) &&
                   precomp_code == $past(wdata[PC_LO +: PRECOMP_W]));

    // R6
    ccr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ccr_wr && !drr_wr) |=> rate_code == $past(wdata[RATE_W-1:0]) &&
                                $stable(precomp_code));

    // R9
    rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(drr_wr || ccr_wr) |=> $stable(rate_code) && $stable(precomp_code));

endmodule

// File: rtl/fdc_status_mux.sv
module fdc_status_mux
    import fdc_host_pkg::*;
(
    input  logic [DATA_W-1:0]   cfg_misc,
    input  logic [TYPE_W-1:0]   drv_type,
    input  logic [1:0]          cfg_tape_drive,
    input  logic [N_DRIVES-1:0] drv_seek_busy,
    input  logic                core_cmd_busy,
    input  logic                core_nondma_exec,
    input  logic                core_dir_to_host,
    input  logic                core_req_master,
    output logic [DATA_W-1:0]   tape_byte,
    output logic [DATA_W-1:0]   msr_byte
);

    always_comb begin
        tape_byte      = '0;
        tape_byte[7:6] = cfg_misc[5:4];
        tape_byte[5:4] = drv_type;
        tape_byte[3:2] = cfg_misc[7:6];
        tape_byte[1:0] = cfg_tape_drive;
    end

    always_comb begin
        msr_byte                 = '0;
        msr_byte[N_DRIVES-1:0]   = drv_seek_busy;
        msr_byte[4]              = core_cmd_busy;
        msr_byte[5]              = core_nondma_exec;
        msr_byte[6]              = core_dir_to_host;
        msr_byte[7]              = core_req_master;
    end

endmodule

// File: rtl/fdc_host_regs.sv
module fdc_host_regs
    import fdc_host_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  bus_addr,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic [7:0]  cfg_misc,
    input  logic [7:0]  cfg_drive_types,
    input  logic [1:0]  cfg_tape_drive,
    input  logic [3:0]  drv_seek_busy,
    input  logic        core_cmd_busy,
    input  logic        core_nondma_exec,
    input  logic        core_dir_to_host,
    input  logic        core_req_master,
    output logic [1:0]  rate_code,
    output logic [2:0]  precomp_code
);

    logic              wr_digout, wr_drr, wr_ccr;
    logic [SEL_W-1:0]  sel_cur;
    logic [TYPE_W-1:0] drv_type;
    logic [DATA_W-1:0] tape_byte, msr_byte;
    rd_state_t         rd_d, rd_q;

    assign wr_digout = bus_wr && (bus_addr == OFS_DIGOUT);
    assign wr_drr    = bus_wr && (bus_addr == OFS_STRATE);
    assign wr_ccr    = bus_wr && (bus_addr == OFS_CFGCTL);

    fdc_sel_track u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_wr    (wr_digout),
        .sel_wdata (bus_wdata[SEL_W-1:0]),
        .cfg_types (cfg_drive_types),
        .sel_out   (sel_cur),
        .drv_type  (drv_type)
    );

    fdc_rate_ctl u_rate (
        .clk          (clk),
        .rst_n        (rst_n),
        .drr_wr       (wr_drr),
        .ccr_wr       (wr_ccr),
        .wdata        (bus_wdata),
        .rate_code    (rate_code),
        .precomp_code (precomp_code)
    );

    fdc_status_mux u_stat (
        .cfg_misc         (cfg_misc),
        .drv_type         (drv_type),
        .cfg_tape_drive   (cfg_tape_drive),
        .drv_seek_busy    (drv_seek_busy),
        .core_cmd_busy    (core_cmd_busy),
        .core_nondma_exec (core_nondma_exec),
        .core_dir_to_host (core_dir_to_host),
        .core_req_master  (core_req_master),
        .tape_byte        (tape_byte),
        .msr_byte         (msr_byte)
    );

    always_comb begin
        rd_d = rd_q;
        if (bus_rd) begin
            case (bus_addr)
                OFS_TAPE:   rd_d.rdata = tape_byte;
                OFS_STRATE: rd_d.rdata = msr_byte;
                default:    rd_d.rdata = UNIMPL_BYTE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign bus_rdata = rd_q.rdata;

    // R8
    unimpl_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr != OFS_TAPE && bus_addr != OFS_STRATE)
            |=> bus_rdata == 8'hFF);

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R4
    status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_STRATE)
            |=> bus_rdata == $past({core_req_master, core_dir_to_host,
                                    core_nondma_exec, core_cmd_busy,
                                    drv_seek_busy}));

    // R11
    other_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != OFS_DIGOUT && bus_addr != OFS_STRATE &&
         bus_addr != OFS_CFGCTL)
            |=> $stable(rate_code) && $stable(precomp_code) && $stable(sel_cur));

endmodule

// File: tb/fdc_host_regs_bench.sv
module fdc_host_regs_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] bus_addr;
    logic       bus_rd, bus_wr;
    logic [7:0] bus_wdata, bus_rdata;
    logic [7:0] cfg_misc, cfg_drive_types;
    logic [1:0] cfg_tape_drive;
    logic [3:0] drv_seek_busy;
    logic       core_cmd_busy, core_nondma_exec, core_dir_to_host, core_req_master;
    logic [1:0] rate_code;
    logic [2:0] precomp_code;

    int checks = 0;
    int errors = 0;
    logic [1:0] exp_sel = 2'd0;

    always #4 clk = ~clk;

    fdc_host_regs u_fdc_host_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cfg_misc(cfg_misc), .cfg_drive_types(cfg_drive_types),
        .cfg_tape_drive(cfg_tape_drive), .drv_seek_busy(drv_seek_busy),
        .core_cmd_busy(core_cmd_busy), .core_nondma_exec(core_nondma_exec),
        .core_dir_to_host(core_dir_to_host), .core_req_master(core_req_master),
        .rate_code(rate_code), .precomp_code(precomp_code)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [2:0] a, output logic [7:0] q);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        q = bus_rdata;
    endtask

    function automatic logic [7:0] exp_tape(input logic [1:0] s);
        return {cfg_misc[5:4], cfg_drive_types[2*s +: 2], cfg_misc[7:6], cfg_tape_drive};
    endfunction

    task automatic t_reset();
        check("R7 rate", {6'd0, rate_code}, 8'h00);
        check("R7 precomp", {5'd0, precomp_code}, 8'h00);
        check("R7 rdata", bus_rdata, 8'h00);
    endtask

    task automatic t_tape_fields();
        logic [7:0] q;
        logic [7:0] misc_pat [4] = '{8'h00, 8'hC0, 8'h30, 8'h90};
        for (int i = 0; i < 4; i++) begin
            cfg_misc = misc_pat[i];
            cfg_drive_types = 8'hE4;
            cfg_tape_drive = 2'(i);
            do_read(3'd3, q);
            check("R1/R3 tape byte", q, exp_tape(exp_sel));
        end
    endtask

    task automatic t_drive_select();
        logic [7:0] q;
        cfg_misc = 8'h50; cfg_tape_drive = 2'b10;
        cfg_drive_types = 8'b00_01_10_11;
        do_read(3'd3, q);
        check("R2 reset selection is drive 0", q, exp_tape(2'd0));
        for (int d = 3; d >= 0; d--) begin
            do_write(3'd2, 8'hFC | 8'(d));
            exp_sel = 2'(d);
            do_read(3'd3, q);
            check("R2 drive type of selected drive", q, exp_tape(exp_sel));
        end
        cfg_drive_types = 8'b11_00_11_00;
        do_read(3'd3, q);
        check("R2 follows config change", q, exp_tape(exp_sel));
    endtask

    task automatic t_status();
        logic [7:0] q;
        logic [7:0] v;
        for (int b = 0; b < 8; b++) begin
            v = 8'h01 << b;
            {core_req_master, core_dir_to_host, core_nondma_exec, core_cmd_busy, drv_seek_busy} = v;
            do_read(3'd4, q);
            check("R4 status walking one", q, v);
        end
        {core_req_master, core_dir_to_host, core_nondma_exec, core_cmd_busy, drv_seek_busy} = 8'hA5;
        do_read(3'd4, q);
        check("R4 status pattern A5", q, 8'hA5);
    endtask

    task automatic t_rates();
        logic [7:0] q;
        do_write(3'd4, 8'b000_101_10);
        check("R5 rate after data rate write", {6'd0, rate_code}, 8'h02);
        check("R5 precomp after data rate write", {5'd0, precomp_code}, 8'h05);
        {core_req_master, core_dir_to_host, core_nondma_exec, core_cmd_busy, drv_seek_busy} = 8'h3C;
        do_read(3'd4, q);
        check("R5 read of offset 4 is status", q, 8'h3C);
        do_write(3'd7, 8'b111_011_01);
        check("R6 rate after config control write", {6'd0, rate_code}, 8'h01);
        check("R6 precomp kept", {5'd0, precomp_code}, 8'h05);
        do_write(3'd4, 8'b000_010_11);
        check("R6 data rate written last wins", {6'd0, rate_code}, 8'h03);
        check("R5 precomp reload", {5'd0, precomp_code}, 8'h02);
        do_write(3'd7, 8'h00);
        check("R6 config control written last wins", {6'd0, rate_code}, 8'h00);
    endtask

    task automatic t_unimpl_and_hold();
        logic [7:0] q;
        logic [2:0] ofs [6] = '{3'd0, 3'd1, 3'd2, 3'd5, 3'd6, 3'd7};
        for (int i = 0; i < 6; i++) begin
            do_read(ofs[i], q);
            check("R8 unimplemented read", q, 8'hFF);
        end
        do_read(3'd3, q);
        cfg_misc = ~cfg_misc;
        {core_req_master, core_dir_to_host, core_nondma_exec, core_cmd_busy, drv_seek_busy} = 8'h00;
        repeat (3) @(negedge clk);
        check("R10 read data holds", bus_rdata, q);
    endtask

    task automatic t_no_side_effects();
        logic [7:0] q;
        logic [1:0] r0;
        logic [2:0] p0;
        r0 = rate_code; p0 = precomp_code;
        for (int a = 0; a < 8; a++) begin
            do_read(3'(a), q);
        end
        check("R9 rate after reads", {6'd0, rate_code}, {6'd0, r0});
        check("R9 precomp after reads", {5'd0, precomp_code}, {5'd0, p0});
        do_read(3'd3, q);
        check("R9 selection after reads", q, exp_tape(exp_sel));
        do_write(3'd0, 8'hFF);
        do_write(3'd1, 8'hFF);
        do_write(3'd3, 8'hFE);
        do_write(3'd5, 8'hFF);
        do_write(3'd6, 8'hFF);
        check("R11 rate after ignored writes", {6'd0, rate_code}, {6'd0, r0});
        check("R11 precomp after ignored writes", {5'd0, precomp_code}, {5'd0, p0});
        do_read(3'd3, q);
        check("R11 selection after ignored writes", q, exp_tape(exp_sel));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        cfg_misc = '0; cfg_drive_types = '0; cfg_tape_drive = '0; drv_seek_busy = '0;
        core_cmd_busy = 1'b0; core_nondma_exec = 1'b0;
        core_dir_to_host = 1'b0; core_req_master = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tape_fields();
        t_drive_select();
        t_status();
        t_rates();
        t_unimpl_and_hold();
        t_no_side_effects();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule